// File: doc/BRIEF.md
# Physical Region Pointer Walker

This block turns a host transfer request into the ordered list of memory segments that a DMA engine must visit. A request names a total byte count and two 64-bit pointers. The first pointer may start anywhere inside a page. The second pointer is either absent, the address of a single data page, or the address of a list of 64-bit page pointers held in host memory. The block reads that list itself through a one-word memory read port. A list may run over several list pages, because the final slot of a full list page can point to the next one.

Segments leave the block one at a time on a valid/ready interface, each as a start address and a byte count. A walk ends with a one-cycle completion pulse that carries a 16-bit status. A walk that meets an invalid pointer stops at once, emits no further segments and reports the failure status. The page size is chosen per walk as a power of two. Moving the data is the job of the DMA engine, not of this block.

Top module: `prpw_walker`

## Requirements
- R1: A walk started with a zero first pointer emits no segment and completes on the next cycle with status 16'h4002 (field invalid, code 0x0002, with the do-not-retry bit 0x4000).
- R2: The page size is 2^(page_sel+PAGE_BASE) bytes. The first segment starts at the first pointer, and its length is the page size minus the pointer's offset within its page, clipped to the transfer length.
- R3: If bytes remain after the first segment and the second pointer is zero, the walk fails with 16'h4002 after that segment. If no bytes remain, the second pointer is never examined.
- R4: If the bytes that remain after the first segment are at most one page, the second pointer is a single data page that carries all of them. It must be page-aligned, or the walk fails with 16'h4002.
- R5: If more than one page remains, the second pointer, with its low three bits cleared, is the address of a list. List words are read in ascending address order, one request at a time, as one-cycle mem_req pulses on 8-byte-aligned addresses. Each returned 64-bit word is one entry, and each entry used as data yields a segment of min(remaining, page size) bytes.
- R6: A list entry used as a data page must be nonzero and page-aligned. Otherwise the walk fails with 16'h4002 and emits nothing more.
- R7: A list slot whose address has bits [exp-1:3] all ones is the last slot of its list page. If more than one page still remains when the walk reaches that slot, the slot's entry is the address of the next list page, must be nonzero and page-aligned (else 16'h4002), and reading continues from it. If a page or less remains, the slot is an ordinary data entry.
- R8: While seg_valid is high and seg_ready is low, seg_valid, seg_addr and seg_len hold their values.
- R9: busy is high from an accepted start until the completion pulse. done is high for exactly one cycle, with status 16'h0000 on success. A start pulse while busy is ignored.
- R10: A nonzero first pointer with a transfer length of zero completes with 16'h0000 and emits no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a walk when idle |
| page_sel | input | MPS_W | Page size exponent minus PAGE_BASE |
| xfer_len | input | LEN_W | Total transfer length in bytes |
| ptr_a | input | 64 | First region pointer |
| ptr_b | input | 64 | Second pointer: data page or list address |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| mem_req | output | 1 | One-cycle list word read request |
| mem_addr | output | 64 | Byte address of the list word |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | List entry value |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| done_status | output | 16 | Completion status, valid with done |

## Verification
The bench builds the walker with PAGE_BASE set to 6, so a page selection of 0 gives 64-byte pages and 8-slot list pages. With pages that small, a walk of ten segments already crosses a list page boundary, and the chaining slot, a bad chain pointer, and a list that starts part-way into its page can all be reached with a few hundred bytes of modelled list memory. A page selection of 1 gives 128-byte pages and 16-slot lists, which shows that the page exponent is taken from the port. The bench also toggles seg_ready throughout its vector walks to exercise backpressure.

// File: rtl/prpw_pkg.sv
package prpw_pkg;

    localparam int PTR_W = 64;

    // Completion codes: field-invalid (0x0002) with do-not-retry (0x4000)
    localparam logic [15:0] ST_OK        = 16'h0000;
    localparam logic [15:0] ST_BAD_FIELD = 16'h4002;

    typedef enum logic [2:0] {
        W_IDLE,
        W_EMIT,
        W_FETCH,
        W_WAIT,
        W_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        SRC_FIRST,
        SRC_DIRECT,
        SRC_LIST
    } seg_src_t;

    function automatic logic [PTR_W-1:0] page_bytes(input logic [7:0] exp_v);
        return {{(PTR_W-1){1'b0}}, 1'b1} << exp_v;
    endfunction

endpackage

// File: rtl/prpw_ptr_check.sv
module prpw_ptr_check
    import prpw_pkg::*;
(
    input  logic [PTR_W-1:0] ptr,
    input  logic [PTR_W-1:0] mask,
    output logic             usable
);
    always_comb usable = (ptr != '0) && ((ptr & mask) == '0);
endmodule

// File: rtl/prpw_len_clip.sv
module prpw_len_clip #(
    parameter int WA = 64,
    parameter int WB = 32
) (
    input  logic [WA-1:0] avail,
    input  logic [WB-1:0] want,
    output logic [WB-1:0] take
);
    always_comb take = (avail < WA'(want)) ? WB'(avail) : want;
endmodule

// File: rtl/prpw_walker.sv
module prpw_walker
    import prpw_pkg::*;
#(
    parameter int PAGE_BASE = 12,
    parameter int MPS_W     = 4,
    parameter int LEN_W     = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [MPS_W-1:0] page_sel,
    input  logic [LEN_W-1:0] xfer_len,
    input  logic [63:0]      ptr_a,
    input  logic [63:0]      ptr_b,
    output logic             seg_valid,
    input  logic             seg_ready,
    output logic [63:0]      seg_addr,
    output logic [LEN_W-1:0] seg_len,
    output logic             mem_req,
    output logic [63:0]      mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [63:0]      mem_rsp_data,
    output logic             busy,
    output logic             done,
    output logic [15:0]      done_status
);
    localparam int EXP_MAX = (1 << MPS_W) - 1 + PAGE_BASE;
    localparam int EXP_W   = $clog2(EXP_MAX + 1);

    walk_state_t      state;
    seg_src_t         src;
    logic [EXP_W-1:0] exp_q;
    logic [LEN_W-1:0] rem_q;
    logic [63:0]      ptr_b_q;
    logic [63:0]      list_ptr;
    logic [63:0]      addr_q;
    logic [LEN_W-1:0] len_q;
    logic [15:0]      status_q;

    // Start-time page geometry from the live inputs
    logic [EXP_W-1:0] start_exp;
    logic [63:0]      start_mask;
    logic [63:0]      first_avail;
    logic [LEN_W-1:0] first_len;

    always_comb begin
        start_exp   = EXP_W'(page_sel) + EXP_W'(PAGE_BASE);
        start_mask  = page_bytes(8'(start_exp)) - 64'd1;
        first_avail = start_mask + 64'd1 - (ptr_a & start_mask);
    end

    prpw_len_clip #(.WA(64), .WB(LEN_W)) u_clip_first (
        .avail (first_avail),
        .want  (xfer_len),
        .take  (first_len)
    );

    // Geometry of the walk in progress
    logic [63:0]      page_q;
    logic [63:0]      mask_q;
    logic [LEN_W-1:0] page_len;
    logic             more_than_page;
    logic             last_slot;
    logic             b_ok;
    logic             entry_ok;

    always_comb begin
        page_q         = page_bytes(8'(exp_q));
        mask_q         = page_q - 64'd1;
        more_than_page = 64'(rem_q) > page_q;
        last_slot      = ((list_ptr | 64'd7) & mask_q) == mask_q;
    end

    prpw_len_clip #(.WA(64), .WB(LEN_W)) u_clip_page (
        .avail (page_q),
        .want  (rem_q),
        .take  (page_len)
    );

    prpw_ptr_check u_chk_b (
        .ptr    (ptr_b_q),
        .mask   (mask_q),
        .usable (b_ok)
    );

    prpw_ptr_check u_chk_entry (
        .ptr    (mem_rsp_data),
        .mask   (mask_q),
        .usable (entry_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= W_IDLE;
            src      <= SRC_FIRST;
            exp_q    <= '0;
            rem_q    <= '0;
            ptr_b_q  <= '0;
            list_ptr <= '0;
            addr_q   <= '0;
            len_q    <= '0;
            status_q <= ST_OK;
        end else begin
            case (state)
                W_IDLE: if (start) begin
                    exp_q   <= start_exp;
                    ptr_b_q <= ptr_b;
                    src     <= SRC_FIRST;
                    if (ptr_a == '0) begin
                        status_q <= ST_BAD_FIELD;
                        state    <= W_DONE;
                    end else if (xfer_len == '0) begin
                        status_q <= ST_OK;
                        state    <= W_DONE;
                    end else begin
                        addr_q <= ptr_a;
                        len_q  <= first_len;
                        rem_q  <= xfer_len - first_len;
                        state  <= W_EMIT;
                    end
                end
                W_EMIT: if (seg_ready) begin
                    if (rem_q == '0) begin
                        status_q <= ST_OK;
                        state    <= W_DONE;
                    end else if (src == SRC_FIRST) begin
                        if (ptr_b_q == '0) begin
                            status_q <= ST_BAD_FIELD;
                            state    <= W_DONE;
                        end else if (!more_than_page) begin
                            if (b_ok) begin
                                addr_q <= ptr_b_q;
                                len_q  <= rem_q;
                                rem_q  <= '0;
                                src    <= SRC_DIRECT;
                            end else begin
                                status_q <= ST_BAD_FIELD;
                                state    <= W_DONE;
                            end
                        end else begin
                            list_ptr <= {ptr_b_q[63:3], 3'b000};
                            src      <= SRC_LIST;
                            state    <= W_FETCH;
                        end
                    end else begin
                        state <= W_FETCH;
                    end
                end
                W_FETCH: state <= W_WAIT;
                W_WAIT: if (mem_rsp_valid) begin
                    if (!entry_ok) begin
                        status_q <= ST_BAD_FIELD;
                        state    <= W_DONE;
                    end else if (last_slot && more_than_page) begin
                        list_ptr <= mem_rsp_data;
                        state    <= W_FETCH;
                    end else begin
                        addr_q   <= mem_rsp_data;
                        len_q    <= page_len;
                        rem_q    <= rem_q - page_len;
                        list_ptr <= list_ptr + 64'd8;
                        state    <= W_EMIT;
                    end
                end
                W_DONE:  state <= W_IDLE;
                default: state <= W_IDLE;
            endcase
        end
    end

    always_comb begin
        seg_valid   = (state == W_EMIT);
        seg_addr    = addr_q;
        seg_len     = len_q;
        mem_req     = (state == W_FETCH);
        mem_addr    = list_ptr;
        busy        = (state != W_IDLE);
        done        = (state == W_DONE);
        done_status = status_q;
    end

endmodule

// File: rtl/prpw_walker_chk.sv
module prpw_walker_chk #(
    parameter int LEN_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [63:0]      ptr_a,
    input logic             seg_valid,
    input logic             seg_ready,
    input logic [63:0]      seg_addr,
    input logic [LEN_W-1:0] seg_len,
    input logic             mem_req,
    input logic [63:0]      mem_addr,
    input logic             busy,
    input logic             done,
    input logic [15:0]      done_status
);
    AST_ZERO_PTR_REJECT: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ptr_a == 64'd0) |=> (done && done_status == 16'h4002)); // R1
    AST_SEG_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        seg_valid |-> (seg_len != '0)); // R2
    AST_MEM_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000)); // R5
    AST_MEM_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req); // R5
    AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len))); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_SEG_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (seg_valid || mem_req || done) |-> busy); // R9
    AST_STATUS_CODE: assert property (@(posedge clk) disable iff (rst)
        done |-> (done_status == 16'h0000 || done_status == 16'h4002)); // R9
endmodule

bind prpw_walker prpw_walker_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/prpw_walker_test.sv
`timescale 1ns/1ps
module prpw_walker_test;

    localparam int LEN_W = 32;
    localparam logic [15:0] OK  = 16'h0000;
    localparam logic [15:0] BAD = 16'h4002;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [3:0]       page_sel = '0;
    logic [LEN_W-1:0] xfer_len = '0;
    logic [63:0]      ptr_a = '0, ptr_b = '0;
    logic             seg_valid, seg_ready = 1'b0;
    logic [63:0]      seg_addr;
    logic [LEN_W-1:0] seg_len;
    logic             mem_req, mem_rsp_valid = 1'b0;
    logic [63:0]      mem_addr, mem_rsp_data = '0;
    logic             busy, done;
    logic [15:0]      done_status;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    prpw_walker #(.PAGE_BASE(6), .MPS_W(4), .LEN_W(LEN_W)) uut (
        .clk(clk), .rst(rst), .start(start), .page_sel(page_sel),
        .xfer_len(xfer_len), .ptr_a(ptr_a), .ptr_b(ptr_b),
        .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
        .seg_len(seg_len), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(done), .done_status(done_status)
    );

    // List memory model: 256 words, one-cycle read latency
    logic [63:0] mem [0:255];
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req;
        mem_rsp_data  <= mem[mem_addr[10:3]];
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Walk results
    int          r_n;
    logic [15:0] r_st;
    logic [63:0] r_last_addr;
    logic [63:0] r_last_len;
    logic [63:0] r_total;

    task automatic launch(input logic [63:0] pa, input logic [63:0] pb,
                          input logic [LEN_W-1:0] len, input logic [3:0] sel);
        @(negedge clk);
        ptr_a = pa; ptr_b = pb; xfer_len = len; page_sel = sel; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic collect(input bit toggle);
        int cyc = 0;
        r_n = 0; r_st = 16'hFFFF; r_last_addr = '0; r_last_len = '0; r_total = '0;
        forever begin
            seg_ready = toggle ? ((cyc % 3) != 1) : 1'b1;
            if (seg_valid && seg_ready) begin
                r_n++;
                r_last_addr = seg_addr;
                r_last_len  = 64'(seg_len);
                r_total     = r_total + 64'(seg_len);
            end
            if (done) begin
                r_st = done_status;
                break;
            end
            if (cyc > 3000) begin
                checks++; fails++;
                $display("FAIL R9 walk timeout: actual busy expected done");
                break;
            end
            cyc++;
            @(negedge clk);
        end
        seg_ready = 1'b0;
    endtask

    typedef struct packed {
        logic [63:0] pa;
        logic [63:0] pb;
        logic [31:0] len;
        logic [3:0]  sel;
        logic [15:0] st;
        logic [7:0]  nseg;
        logic [63:0] last_addr;
        logic [31:0] last_len;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{64'h0,    64'h0,    32'd100, 4'd0, BAD, 8'd0,  64'h0,     32'd0},  // R1
        '{64'h1010, 64'h0,    32'd40,  4'd0, OK,  8'd1,  64'h1010,  32'd40}, // R2
        '{64'h1010, 64'h0,    32'd48,  4'd0, OK,  8'd1,  64'h1010,  32'd48}, // R2
        '{64'h1010, 64'h0,    32'd100, 4'd0, BAD, 8'd1,  64'h1010,  32'd48}, // R3
        '{64'h1010, 64'h2000, 32'd100, 4'd0, OK,  8'd2,  64'h2000,  32'd52}, // R4
        '{64'h1010, 64'h2000, 32'd112, 4'd0, OK,  8'd2,  64'h2000,  32'd64}, // R4
        '{64'h1010, 64'h2004, 32'd100, 4'd0, BAD, 8'd1,  64'h1010,  32'd48}, // R4
        '{64'h1000, 64'h100,  32'd129, 4'd0, OK,  8'd3,  64'h11000, 32'd1},  // R5
        '{64'h1000, 64'h300,  32'd200, 4'd0, BAD, 8'd2,  64'h30000, 32'd64}, // R6
        '{64'h1000, 64'h340,  32'd200, 4'd0, BAD, 8'd1,  64'h1000,  32'd64}, // R6
        '{64'h1000, 64'h100,  32'd640, 4'd0, OK,  8'd10, 64'h21000, 32'd64}, // R7
        '{64'h1000, 64'h100,  32'd576, 4'd0, OK,  8'd9,  64'h200,   32'd64}, // R7
        '{64'h1000, 64'h380,  32'd640, 4'd0, BAD, 8'd8,  64'h46000, 32'd64}, // R7
        '{64'h1000, 64'h130,  32'd256, 4'd0, OK,  8'd4,  64'h21000, 32'd64}, // R7
        '{64'h1040, 64'h400,  32'd200, 4'd1, OK,  8'd3,  64'h8080,  32'd8},  // R2
        '{64'h1000, 64'h0,    32'd0,   4'd0, OK,  8'd0,  64'h0,     32'd0},  // R10
        '{64'h1000, 64'h0,    32'd64,  4'd0, OK,  8'd1,  64'h1000,  32'd64}, // R3
        '{64'h1000, 64'h104,  32'd129, 4'd0, OK,  8'd3,  64'h11000, 32'd1}   // R5
    };

    function automatic string req_of(input int i);
        case (i)
            0:                return "R1";
            1, 2, 14:         return "R2";
            3, 16:            return "R3";
            4, 5, 6:          return "R4";
            7, 17:            return "R5";
            8, 9:             return "R6";
            15:               return "R10";
            default:          return "R7";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // list A at 0x100: seven data pages, last slot chains to 0x200
        for (int k = 0; k < 7; k++) mem[(16'h100 >> 3) + k] = 64'h10000 + 64'(k) * 64'h1000;
        mem[(16'h100 >> 3) + 7] = 64'h200;
        // list B at 0x200
        for (int k = 0; k < 8; k++) mem[(16'h200 >> 3) + k] = 64'h20000 + 64'(k) * 64'h1000;
        // list at 0x300: second entry zero
        mem[16'h300 >> 3] = 64'h30000;
        // list at 0x340: misaligned first entry
        mem[16'h340 >> 3] = 64'h5010;
        // list at 0x380: misaligned chain pointer in the last slot
        for (int k = 0; k < 7; k++) mem[(16'h380 >> 3) + k] = 64'h40000 + 64'(k) * 64'h1000;
        mem[(16'h380 >> 3) + 7] = 64'h2A0;
        // list at 0x400 for 128-byte pages
        mem[16'h400 >> 3]       = 64'h8000;
        mem[(16'h400 >> 3) + 1] = 64'h8080;

        repeat (3) @(negedge clk);
        // Reset state
        check("R9", "busy after reset", 64'(busy), 64'd0);
        check("R9", "done after reset", 64'(done), 64'd0);
        check("R8", "seg_valid after reset", 64'(seg_valid), 64'd0);
        check("R5", "mem_req after reset", 64'(mem_req), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            launch(VECS[i].pa, VECS[i].pb, VECS[i].len, VECS[i].sel);
            collect(1'b1);
            check(req_of(i), $sformatf("vec%0d status", i), 64'(r_st), 64'(VECS[i].st));
            check(req_of(i), $sformatf("vec%0d segments", i), 64'(r_n), 64'(VECS[i].nseg));
            if (VECS[i].nseg != 0) begin
                check(req_of(i), $sformatf("vec%0d last addr", i), r_last_addr, VECS[i].last_addr);
                check(req_of(i), $sformatf("vec%0d last len", i), r_last_len, 64'(VECS[i].last_len));
            end
            if (VECS[i].st == OK)
                check(req_of(i), $sformatf("vec%0d byte total", i), r_total, 64'(VECS[i].len));
            @(negedge clk);
            check("R9", $sformatf("vec%0d done width", i), 64'(done), 64'd0);
        end

        // R8: backpressure holds the first segment
        launch(64'h1010, 64'h2000, 32'd100, 4'd0);
        seg_ready = 1'b0;
        repeat (6) @(negedge clk);
        check("R8", "held valid", 64'(seg_valid), 64'd1);
        check("R8", "held addr", seg_addr, 64'h1010);
        check("R8", "held len", 64'(seg_len), 64'd48);
        check("R9", "busy during walk", 64'(busy), 64'd1);
        // R9: a start while busy is ignored
        ptr_a = 64'h0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        collect(1'b0);
        check("R9", "start while busy status", 64'(r_st), 64'(OK));
        check("R9", "start while busy segments", 64'(r_n), 64'd2);
        check("R9", "start while busy last", r_last_addr, 64'h2000);
        @(negedge clk);
        check("R9", "idle after done", 64'(busy), 64'd0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R9 watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule